// File: doc/BRIEF.md
# Configurable frame byte extractor

This block watches a received Ethernet frame as a byte stream that begins with the preamble. From that stream it picks out up to four bytes and packs them into a single 32-bit property word for a receive-queue filer. Each byte is located by a 2-bit anchor code and a 6-bit unsigned offset taken from one 32-bit configuration word. The anchor is one of three header boundaries that an external parser reports with a one-beat mark. Because offsets count from these boundaries and not from frame start, a selector can follow variable-length headers. The destination-address anchor subtracts eight from the offset, so that a selector can reach back into the preamble and start-of-frame delimiter.

The input is a valid/ready byte stream. The block never applies back-pressure: `in_ready` is held high, and a byte is consumed on every cycle that `in_valid` is high. The result leaves as a plain one-cycle strobe with the packed word. The output has no ready, so a downstream consumer must take the word in the cycle it is offered. Headers are not parsed here. The parser's marks are trusted as given, even when the parser did not recognise the header that the mark ends.

Top module: `frame_byte_picker`

## Requirements
- R1: After reset, `out_valid` is 0, `out_word` is 0 and `in_ready` is 1.
- R2: A slot whose anchor code is 00 is never extracted, and its byte of `out_word` reads 0x00.
- R3: Code 01 places the byte at (offset - 8) beats from the beat marked by `mark_da`. Offsets 0..7 select bytes from up to eight beats before that mark within the same frame. A position before the frame's first beat reads 0x00.
- R4: Code 10 places the byte at `offset` beats after the beat marked by `mark_l2`, where offset 0 is the marked beat itself.
- R5: Code 11 places the byte at `offset` beats after the beat marked by `mark_l3`, where offset 0 is the marked beat itself.
- R6: Slot k (k = 0..3) takes its code from `cfg_in[31-8k -: 2]` and its offset from `cfg_in[29-8k -: 6]`. Slot 0 fills `out_word[31:24]` and slot 3 fills `out_word[7:0]`.
- R7: Only the first mark of the slot's anchor kind within a frame arms a slot. Later marks of the same kind in that frame are ignored.
- R8: If the frame ends before the target beat, or the anchor mark never comes, that slot reads 0x00. A byte located on the end-of-frame beat itself is captured.
- R9: `out_valid` pulses high for exactly one cycle, in the cycle after the beat that carries `in_eof`. `out_word` is valid in that cycle. A next frame may start in that same cycle.
- R10: `cfg_in` is sampled on the beat that carries `in_sof`. A change during a frame takes effect only from the next frame.
- R11: Beats after an end of frame and before the next `in_sof` are ignored, including their marks and `in_eof`. Cycles with `in_valid` low neither count as beats nor advance any offset.
- R12: `in_ready` stays 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_in | input | 32 | Four slot selectors, each made of a 2-bit code and a 6-bit offset |
| in_valid | input | 1 | Byte present on `in_data` |
| in_ready | output | 1 | Always 1, so no back-pressure |
| in_data | input | 8 | Received frame byte |
| in_sof | input | 1 | Beat is the first byte of the frame (first preamble byte) |
| in_eof | input | 1 | Beat is the last byte of the frame |
| mark_da | input | 1 | Beat is the first destination-address byte |
| mark_l2 | input | 1 | Beat is the first byte after the layer-2 header |
| mark_l3 | input | 1 | Beat is the first byte after the layer-3 header |
| out_valid | output | 1 | One-cycle strobe carrying the packed word |
| out_word | output | 32 | Packed word {slot0, slot1, slot2, slot3} |

## Verification
Two things can fall in the same cycle. A slot's capture can land on the end-of-frame beat, and the result strobe of one frame can coincide with the start beat of the next frame. The bench provokes the first by aiming one slot at the last byte of several frames. It provokes the second by sending frames back to back with no idle cycle, and one frame carries `in_sof` and `in_eof` on a single beat. The scoreboard expects the final byte in the word, and it expects the following frame's result to be unaffected by the overlap. A configuration change in the middle of a frame, together with stray beats that fall between frames, checks that neither leaks into a result.

// File: rtl/fbp_pkg.sv
`timescale 1ns/1ps
package fbp_pkg;
  typedef enum logic [1:0] {
    ANC_OFF = 2'b00,
    ANC_DA  = 2'b01,
    ANC_L2  = 2'b10,
    ANC_L3  = 2'b11
  } anchor_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CODE_W = 2;
endpackage

// File: rtl/fbp_history.sv
`timescale 1ns/1ps
module fbp_history #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beat,
  input  logic               start,
  input  logic [W-1:0]       data,
  output logic [DEPTH*W-1:0] hist_o
);
  localparam int unsigned HW = DEPTH * W;

  logic [HW-1:0] hist_q;

  // byte k of hist_q is the byte seen k+1 beats ago (k = 0 most recent)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (beat) begin
      if (start) hist_q <= {{(HW-W){1'b0}}, data};
      else       hist_q <= {hist_q[HW-W-1:0], data};
    end
  end

  // on the start beat nothing earlier belongs to this frame
  assign hist_o = start ? '0 : hist_q;
endmodule

// File: rtl/fbp_slot.sv
`timescale 1ns/1ps
module fbp_slot
  import fbp_pkg::*;
#(
  parameter int unsigned OFF_W = 6,
  parameter int unsigned PRE_N = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    beat,
  input  logic                    start,
  input  logic [CODE_W-1:0]       code,
  input  logic [OFF_W-1:0]        off,
  input  logic [BYTE_W-1:0]       data,
  input  logic                    mk_da,
  input  logic                    mk_l2,
  input  logic                    mk_l3,
  input  logic [PRE_N*BYTE_W-1:0] hist,
  output logic [BYTE_W-1:0]       got_d,
  output logic [BYTE_W-1:0]       got_q
);
  logic             armed_q, armed_d;
  logic             seen_q, seen_d;
  logic [OFF_W-1:0] cnt_q, cnt_d;
  logic             hit, back;
  logic [OFF_W-1:0] tgt;
  logic [BYTE_W-1:0] pre_byte;

  always_comb begin
    unique case (code)
      ANC_DA:  hit = mk_da;
      ANC_L2:  hit = mk_l2;
      ANC_L3:  hit = mk_l3;
      default: hit = 1'b0;
    endcase
    back = (code == ANC_DA) && (off < OFF_W'(PRE_N));
    tgt  = (code == ANC_DA) ? off - OFF_W'(PRE_N) : off;
  end

  // offset o < PRE_N on the DA anchor points PRE_N-o beats back
  always_comb begin
    pre_byte = '0;
    for (int k = 0; k < PRE_N; k++) begin
      if (off == OFF_W'(PRE_N - 1 - k)) pre_byte = hist[k*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    armed_d = armed_q;
    seen_d  = seen_q;
    cnt_d   = cnt_q;
    got_d   = got_q;
    if (start) begin
      armed_d = 1'b0;
      seen_d  = 1'b0;
      cnt_d   = '0;
      got_d   = '0;
    end
    if (beat) begin
      if (armed_d) begin
        if (cnt_d == tgt) begin
          got_d   = data;
          armed_d = 1'b0;
        end else begin
          cnt_d = cnt_d + 1'b1;
        end
      end else if (!seen_d && hit) begin
        seen_d = 1'b1;
        if (back)              got_d = pre_byte;
        else if (tgt == '0)    got_d = data;
        else begin
          armed_d = 1'b1;
          cnt_d   = OFF_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      seen_q  <= 1'b0;
      cnt_q   <= '0;
      got_q   <= '0;
    end else begin
      armed_q <= armed_d;
      seen_q  <= seen_d;
      cnt_q   <= cnt_d;
      got_q   <= got_d;
    end
  end

  // R7: once anchored, a slot stays anchored until the next start beat
  a_r7_anchor_held: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && !start |=> seen_q);

  // R8: a running count never passes its target
  a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && !start |-> cnt_q <= tgt);

  // R2: a disabled slot neither arms nor holds a byte
  a_r2_off_slot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (code == ANC_OFF) && !start |-> !armed_q && (got_q == '0));
endmodule

// File: rtl/frame_byte_picker.sv
`timescale 1ns/1ps
module frame_byte_picker
  import fbp_pkg::*;
#(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned OFF_W = 6,
  parameter int unsigned PRE_N = 8,
  localparam int unsigned SLOT_W = CODE_W + OFF_W,
  localparam int unsigned CFG_W  = SLOTS * SLOT_W,
  localparam int unsigned WORD_W = SLOTS * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_in,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              mark_da,
  input  logic              mark_l2,
  input  logic              mark_l3,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word
);
  logic                    in_frame_q;
  logic [CFG_W-1:0]        cfg_q, cfg_eff;
  logic                    sof_b, beat, eof_b;
  logic [PRE_N*BYTE_W-1:0] hist;
  logic [WORD_W-1:0]       word_d, word_q_all;

  assign in_ready = 1'b1;
  assign sof_b    = in_valid & in_sof;
  assign beat     = in_valid & (in_sof | in_frame_q);
  assign eof_b    = beat & in_eof;
  assign cfg_eff  = sof_b ? cfg_in : cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      cfg_q      <= '0;
    end else begin
      if (sof_b)      cfg_q <= cfg_in;
      if (eof_b)      in_frame_q <= 1'b0;
      else if (sof_b) in_frame_q <= 1'b1;
    end
  end

  fbp_history #(.DEPTH(PRE_N), .W(BYTE_W)) u_hist (
    .clk   (clk),
    .rst_n (rst_n),
    .beat  (beat),
    .start (sof_b),
    .data  (in_data),
    .hist_o(hist)
  );

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    localparam int unsigned TOP = CFG_W - 1 - g * SLOT_W;
    localparam int unsigned WB  = WORD_W - 1 - g * BYTE_W;
    logic [BYTE_W-1:0] got_d, got_q;

    fbp_slot #(.OFF_W(OFF_W), .PRE_N(PRE_N)) u_slot (
      .clk  (clk),
      .rst_n(rst_n),
      .beat (beat),
      .start(sof_b),
      .code (cfg_eff[TOP -: CODE_W]),
      .off  (cfg_eff[TOP-CODE_W -: OFF_W]),
      .data (in_data),
      .mk_da(mark_da),
      .mk_l2(mark_l2),
      .mk_l3(mark_l3),
      .hist (hist),
      .got_d(got_d),
      .got_q(got_q)
    );

    assign word_d[WB -: BYTE_W]     = got_d;
    assign word_q_all[WB -: BYTE_W] = got_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= eof_b;
      if (eof_b) out_word <= word_d;
    end
  end

  // R10: the sampled configuration holds for the whole frame
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    in_frame_q && !sof_b |=> $stable(cfg_q));

  // R11: between frames no slot changes what it holds
  a_r11_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !in_frame_q && !sof_b |=> $stable(word_q_all));

  // R9: the word only changes alongside a result strobe
  a_r9_word_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_word));

  // R12: never back-pressures
  a_r12_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> in_ready);
endmodule

// File: tb/tb_frame_byte_picker.sv
`timescale 1ns/1ps
module tb_frame_byte_picker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cfg_in;
  logic        in_valid, in_ready, in_sof, in_eof;
  logic [7:0]  in_data;
  logic        mark_da, mark_l2, mark_l3;
  logic        out_valid;
  logic [31:0] out_word;

  int total = 0;
  int bad   = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  logic [7:0] fr [256];
  int flen, da_i, l2_i, l3_i, dup_i;

  always #2 clk = ~clk;

  frame_byte_picker dut (
    .clk(clk), .rst_n(rst_n), .cfg_in(cfg_in),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof),
    .mark_da(mark_da), .mark_l2(mark_l2), .mark_l3(mark_l3),
    .out_valid(out_valid), .out_word(out_word)
  );

  function automatic logic [31:0] mk(input logic [1:0] c0, input logic [5:0] o0,
                                     input logic [1:0] c1, input logic [5:0] o1,
                                     input logic [1:0] c2, input logic [5:0] o2,
                                     input logic [1:0] c3, input logic [5:0] o3);
    return {c0, o0, c1, o1, c2, o2, c3, o3};
  endfunction

  function automatic logic [7:0] ref_byte(input logic [1:0] c, input logic [5:0] o);
    int a, pos;
    case (c)
      2'b01:   a = da_i;
      2'b10:   a = l2_i;
      2'b11:   a = l3_i;
      default: a = -1;
    endcase
    if (a < 0) return 8'h00;
    pos = a + int'(o) - ((c == 2'b01) ? 8 : 0);
    if (pos < 0 || pos >= flen) return 8'h00;
    return fr[pos];
  endfunction

  function automatic logic [31:0] ref_word(input logic [31:0] cfg);
    logic [31:0] w;
    for (int s = 0; s < 4; s++)
      w[31-8*s -: 8] = ref_byte(cfg[31-8*s -: 2], cfg[29-8*s -: 6]);
    return w;
  endfunction

  task automatic fill(input int len, input int seed, input int pre_n,
                      input int l2, input int l3);
    flen = len; da_i = pre_n; l2_i = l2; l3_i = l3; dup_i = -1;
    for (int i = 0; i < len; i++) begin
      if (i < pre_n) fr[i] = (i == pre_n - 1) ? 8'hD5 : 8'h55;
      else           fr[i] = 8'((i * seed + 17) & 8'hFF);
    end
  endtask

  task automatic idle();
    @(posedge clk); #1;
    in_valid = 0; in_sof = 0; in_eof = 0;
    mark_da = 0; mark_l2 = 0; mark_l3 = 0;
  endtask

  // driver: pushes expected word, then plays the frame
  task automatic send(input string tag, input bit gaps, input int chg_at,
                      input logic [31:0] chg_cfg);
    exp_q.push_back(ref_word(cfg_in));
    tag_q.push_back(tag);
    for (int i = 0; i < flen; i++) begin
      @(posedge clk); #1;
      if (gaps && (i % 4 == 2)) begin
        in_valid = 0; in_data = 8'hEE; in_sof = 0; in_eof = 1;
        mark_da = 1; mark_l2 = 1; mark_l3 = 1;
        @(posedge clk); #1;
      end
      in_valid = 1;
      in_data  = fr[i];
      in_sof   = (i == 0);
      in_eof   = (i == flen - 1);
      mark_da  = (i == da_i) || (i == dup_i);
      mark_l2  = (i == l2_i) || (i == dup_i);
      mark_l3  = (i == l3_i);
      if (i == chg_at) cfg_in = chg_cfg;
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R9/R11 unexpected strobe: actual word=%h expected no strobe", out_word);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (out_word !== e) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", t, out_word, e);
          end
        end
        total++;
        if (in_ready !== 1'b1) begin
          bad++;
          $display("FAIL R12 in_ready: actual=%b expected=1", in_ready);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R9: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_in = '0; in_valid = 0; in_data = 0; in_sof = 0; in_eof = 0;
    mark_da = 0; mark_l2 = 0; mark_l3 = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    total++; if (out_valid !== 1'b0) begin bad++; $display("FAIL R1 out_valid: actual=%b expected=0", out_valid); end
    total++; if (out_word !== 32'h0) begin bad++; $display("FAIL R1 out_word: actual=%h expected=0", out_word); end
    total++; if (in_ready !== 1'b1) begin bad++; $display("FAIL R1 in_ready: actual=%b expected=1", in_ready); end

    // R3 R4 R5 R6: preamble byte, DA byte, L2 and L3 relative
    fill(64, 7, 8, 22, 42);
    cfg_in = mk(2'b01, 6'd7, 2'b01, 6'd8, 2'b10, 6'd13, 2'b11, 6'd0);
    send("R3/R4/R5/R6 mixed anchors", 0, -1, '0);
    idle(); idle();

    // R2 R3: disabled slots read zero, first preamble byte
    fill(48, 5, 8, 22, 40);
    cfg_in = mk(2'b00, 6'd5, 2'b10, 6'd3, 2'b00, 6'd9, 2'b01, 6'd0);
    send("R2/R3 disabled slots", 0, -1, '0);
    idle();

    // R8: early end, missing anchor, capture on end beat
    fill(30, 3, 8, 22, -1);
    cfg_in = mk(2'b11, 6'd2, 2'b10, 6'd20, 2'b10, 6'd7, 2'b01, 6'd63);
    send("R8 early end and last-beat capture", 0, -1, '0);
    idle(); idle(); idle();

    // R7 R10 R11: gaps with stray marks, duplicate anchors, mid-frame cfg change
    fill(64, 11, 8, 22, 42);
    dup_i  = 30;
    cfg_in = mk(2'b10, 6'd0, 2'b11, 6'd5, 2'b01, 6'd9, 2'b01, 6'd4);
    send("R7/R10/R11 dup anchors, gaps, cfg change", 1, 20,
         mk(2'b01, 6'd7, 2'b00, 6'd0, 2'b11, 6'd63, 2'b10, 6'd1));

    // R9 R10: back to back, new cfg takes effect here
    fill(110, 13, 8, 22, 42);
    send("R9/R10 back-to-back frame with new cfg", 0, -1, '0);

    // R11: stray beats outside a frame, with marks and an end flag
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #1;
      in_valid = 1; in_data = 8'(8'hA0 + k); in_sof = 0; in_eof = (k == 3);
      mark_da = 1; mark_l2 = 1; mark_l3 = 1;
    end
    idle(); idle(); idle();

    // R3: short preamble, reach before frame start reads zero
    fill(50, 9, 3, 17, 37);
    cfg_in = mk(2'b01, 6'd2, 2'b01, 6'd6, 2'b01, 6'd5, 2'b10, 6'd32);
    send("R3/R8 short preamble", 0, -1, '0);

    // R9: single-beat frame right behind, start and end together
    fill(1, 1, 0, -1, -1);
    fr[0]  = 8'h5A;
    cfg_in = mk(2'b01, 6'd8, 2'b01, 6'd7, 2'b00, 6'd0, 2'b01, 6'd8);
    send("R9 single-beat frame", 0, -1, '0);
    idle();
    repeat (6) @(posedge clk);
    @(negedge clk);

    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R9 missing strobes: actual=%0d pending expected=0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule